// File: doc/BRIEF.md
# Cascaded Codec Serial Port

This block is the device-side serial port of one codec that sits in a chain of identical codecs sharing a single host serial link. Words arrive on a serial input framed by an input frame sync and leave on a serial output framed by an output frame sync. A chain is built by feeding each device's output into the next device's input, with the last device's output going back to the host.

After reset the port is in program mode. In this mode a control word carries a hop count. A device that sees a hop count of zero keeps the word and writes one of its three configuration registers. A device that sees a non-zero hop count sends the word on with the count reduced by one. Words that are not control words, such as an upstream device's ADC sample, pass through unchanged. Setting the mode bit of register A switches the port to data mode. In data mode every received word is a DAC sample. The port counts incoming frames. It forwards all of them except the last one of each group, whose size is the programmed chain length. It keeps that last word as its DAC sample and then starts the count again. At each sampling event the port also sends its own ADC word.

Top module: `chain_codec_port`

## Requirements
- R1: While reset is held and in the cycle after it is released, `cfg_a`, `cfg_b`, `cfg_c`, `frm_out`, `bit_out` and `dac_valid` are all zero. The port is in program mode with a chain-length field of 0.
- R2: A frame is a one-cycle pulse on the frame line, followed in the next 16 cycles by 16 data bits, MSB first. This framing applies to both input and output. The output frame pulse never lasts two cycles in a row.
- R3: Control word layout: bit 15 = 1 marks a control word, bits 14:12 hold the hop count, bits 10:8 select the register (0 = A, 1 = B, 2 = C), and bits 7:0 hold the value. In program mode a control word with hop count 0 writes the selected register and is not retransmitted. A selector of 3 to 7 discards the word without writing anything.
- R4: In program mode a control word with a non-zero hop count is retransmitted with the hop count reduced by one and all other bits unchanged. Its output frame pulse is visible 18 cycles after the cycle in which the input frame pulse was driven.
- R5: In program mode a word with bit 15 = 0 is retransmitted unchanged, with the same 18-cycle latency.
- R6: A one-cycle `sample_evt` pulse causes `adc_word` to be transmitted. The output frame pulse is visible 2 cycles after the cycle in which `sample_evt` was driven.
- R7: A register write takes effect on the clock edge that samples bit 0 of its word, 17 cycles after the input frame pulse is driven. Before that edge the old value is still visible.
- R8: Register A bit 7 = 1 selects data mode. In data mode every word is a DAC word whatever its bit 15, and no register is written. The chain length N is register A bits 2:0, where 0 means 8.
- R9: In data mode the words of each group of N frames are handled as follows. The first N-1 words are retransmitted unchanged. The Nth word is placed on `dac_word`, `dac_valid` pulses for one cycle on the edge that samples its bit 0, the word is not retransmitted, and the count restarts.
- R10: Once the port is in data mode, only reset returns it to program mode. Register A reads back the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_evt | input | 1 | One-cycle pulse marking a sampling event |
| adc_word | input | 16 | ADC word sent at a sampling event |
| frm_in | input | 1 | Input frame sync |
| bit_in | input | 1 | Serial data in |
| bit_out | output | 1 | Serial data out |
| frm_out | output | 1 | Output frame sync |
| dac_word | output | 16 | Last DAC word kept by this device |
| dac_valid | output | 1 | One-cycle pulse when `dac_word` updates |
| cfg_a | output | 8 | Register A: bit 7 mode, bits 2:0 chain length |
| cfg_b | output | 8 | Register B contents |
| cfg_c | output | 8 | Register C contents |

## Verification
The results of an input frame are due at different cycles. Register updates, `dac_word` and the `dac_valid` pulse appear 17 cycles after the frame pulse is driven. A retransmitted word's frame pulse appears at 18 cycles, and its bits follow over the next 16 cycles. An ADC frame pulse appears 2 cycles after `sample_evt`. The bench drives inputs and samples outputs on falling edges and keeps a cycle counter. It timestamps the frame pulses it observes and compares the differences against these exact figures. It checks register and DAC outputs on the falling edge that ends a word. For R7 it also samples one cycle earlier to confirm that the old value is still present.

// File: rtl/chain_codec_pkg.sv
package chain_codec_pkg;

    localparam int WORD_W   = 16;
    localparam int HOP_W    = 3;
    localparam int SEL_W    = 3;
    localparam int VAL_W    = 8;
    localparam int LEN_W    = 3;
    localparam int MODE_BIT = 7;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int GRP_W    = LEN_W + 1;

    typedef struct packed {
        logic               is_ctl;
        logic [HOP_W-1:0]   hop;
        logic               spare;
        logic [SEL_W-1:0]   sel;
        logic [VAL_W-1:0]   val;
    } ctl_word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_A = 3'd0,
        SEL_B = 3'd1,
        SEL_C = 3'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA
    } tx_state_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [VAL_W-1:0] val;
    } reg_wr_t;

    // chain length field: zero stands for the largest group
    function automatic logic [GRP_W-1:0] chain_len(input logic [LEN_W-1:0] f);
        return (f == '0) ? GRP_W'(1 << LEN_W) : GRP_W'(f);
    endfunction

    function automatic ctl_word_t drop_hop(input ctl_word_t w);
        ctl_word_t r;
        r     = w;
        r.hop = w.hop - 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ccp_rx.sv
module ccp_rx
    import chain_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_in,
    input  logic              bit_in,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] sh_q;

    // word completes on the edge that samples the last bit
    assign done = (left_q == CNT_W'(1));
    assign word = {sh_q[WORD_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            sh_q   <= '0;
        end else begin
            if (left_q != '0) begin
                sh_q   <= {sh_q[WORD_W-2:0], bit_in};
                left_q <= left_q - 1'b1;
            end
            if (frm_in) begin
                left_q <= CNT_W'(WORD_W);
            end
        end
    end
endmodule

// File: rtl/ccp_router.sv
module ccp_router
    import chain_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              data_mode,
    input  logic [LEN_W-1:0]  len_field,
    output reg_wr_t           wr,
    output logic              fwd_req,
    output logic [WORD_W-1:0] fwd_word,
    output logic              dac_ld
);
    ctl_word_t        cw;
    logic [GRP_W-1:0] grp_q;
    logic [GRP_W-1:0] grp_n;
    logic [GRP_W-1:0] len_eff;

    assign cw      = ctl_word_t'(word);
    assign len_eff = chain_len(len_field);
    assign grp_n   = grp_q + GRP_W'(1);

    always_comb begin
        wr       = '{wr: 1'b0, sel: SEL_A, val: '0};
        fwd_req  = 1'b0;
        fwd_word = word;
        dac_ld   = 1'b0;
        if (done) begin
            if (data_mode) begin
                if (grp_n == len_eff) dac_ld  = 1'b1;
                else                  fwd_req = 1'b1;
            end else if (cw.is_ctl) begin
                if (cw.hop == '0) begin
                    wr.wr  = (cw.sel <= SEL_W'(SEL_C));
                    wr.sel = reg_sel_e'(cw.sel);
                    wr.val = cw.val;
                end else begin
                    fwd_req  = 1'b1;
                    fwd_word = drop_hop(cw);
                end
            end else begin
                fwd_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !data_mode) begin
            grp_q <= '0;
        end else if (done) begin
            grp_q <= dac_ld ? '0 : grp_n;
        end
    end

    // at most one outcome per received word
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr.wr, fwd_req, dac_ld}));

    assert_dac_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
        dac_ld |-> data_mode);

    assert_group_bound_R9: assert property (@(posedge clk) disable iff (rst)
        grp_q < len_eff);

    assert_no_write_in_data_R8: assert property (@(posedge clk) disable iff (rst)
        data_mode |-> !wr.wr);

    // a forwarded control word in program mode carried a non-zero hop count
    assert_fwd_hop_R4: assert property (@(posedge clk) disable iff (rst)
        (fwd_req && !data_mode && cw.is_ctl) |-> (cw.hop != '0));
endmodule

// File: rtl/ccp_regs.sv
module ccp_regs
    import chain_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    output logic [VAL_W-1:0] reg_a,
    output logic [VAL_W-1:0] reg_b,
    output logic [VAL_W-1:0] reg_c
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
            reg_c <= '0;
        end else if (wr.wr) begin
            case (wr.sel)
                SEL_A:   reg_a <= wr.val;
                SEL_B:   reg_b <= wr.val;
                SEL_C:   reg_c <= wr.val;
                default: ;
            endcase
        end
    end

    assert_mode_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        reg_a[MODE_BIT] |=> reg_a[MODE_BIT]);

    assert_b_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !wr.wr |=> $stable(reg_b));
endmodule

// File: rtl/ccp_tx.sv
module ccp_tx
    import chain_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_req,
    input  logic [WORD_W-1:0] adc_word,
    input  logic              fwd_req,
    input  logic [WORD_W-1:0] fwd_word,
    output logic              bit_out,
    output logic              frm_out
);
    tx_state_e         st_q;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] sh_q;
    logic              adc_pv_q, fwd_pv_q;
    logic [WORD_W-1:0] adc_pw_q, fwd_pw_q;
    logic              can_load;

    assign can_load = (st_q == TX_IDLE) || (st_q == TX_DATA && left_q == CNT_W'(1));
    assign frm_out  = (st_q == TX_SYNC);
    assign bit_out  = (st_q == TX_DATA) ? sh_q[WORD_W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= TX_IDLE;
            left_q   <= '0;
            sh_q     <= '0;
            adc_pv_q <= 1'b0;
            fwd_pv_q <= 1'b0;
            adc_pw_q <= '0;
            fwd_pw_q <= '0;
        end else begin
            case (st_q)
                TX_SYNC: begin
                    st_q   <= TX_DATA;
                    left_q <= CNT_W'(WORD_W);
                end
                TX_DATA: begin
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) st_q <= TX_IDLE;
                end
                default: ;
            endcase
            // own sample has precedence over a waiting forwarded word
            if (can_load && (adc_pv_q || fwd_pv_q)) begin
                st_q <= TX_SYNC;
                if (adc_pv_q) begin
                    sh_q     <= adc_pw_q;
                    adc_pv_q <= 1'b0;
                end else begin
                    sh_q     <= fwd_pw_q;
                    fwd_pv_q <= 1'b0;
                end
            end
            if (adc_req) begin
                adc_pv_q <= 1'b1;
                adc_pw_q <= adc_word;
            end
            if (fwd_req) begin
                fwd_pv_q <= 1'b1;
                fwd_pw_q <= fwd_word;
            end
        end
    end

    assert_frame_single_R2: assert property (@(posedge clk) disable iff (rst)
        frm_out |=> !frm_out);

    assert_data_after_frame_R2: assert property (@(posedge clk) disable iff (rst)
        frm_out |=> (st_q == TX_DATA && left_q == CNT_W'(WORD_W)));
endmodule

// File: rtl/chain_codec_port.sv
module chain_codec_port
    import chain_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_evt,
    input  logic [WORD_W-1:0] adc_word,
    input  logic              frm_in,
    input  logic              bit_in,
    output logic              bit_out,
    output logic              frm_out,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    output logic [VAL_W-1:0]  cfg_a,
    output logic [VAL_W-1:0]  cfg_b,
    output logic [VAL_W-1:0]  cfg_c
);
    logic              rx_done;
    logic [WORD_W-1:0] rx_word;
    reg_wr_t           wr;
    logic              fwd_req;
    logic [WORD_W-1:0] fwd_word;
    logic              dac_ld;

    ccp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .frm_in (frm_in),
        .bit_in (bit_in),
        .done   (rx_done),
        .word   (rx_word)
    );

    ccp_router u_router (
        .clk       (clk),
        .rst       (rst),
        .done      (rx_done),
        .word      (rx_word),
        .data_mode (cfg_a[MODE_BIT]),
        .len_field (cfg_a[LEN_W-1:0]),
        .wr        (wr),
        .fwd_req   (fwd_req),
        .fwd_word  (fwd_word),
        .dac_ld    (dac_ld)
    );

    ccp_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .reg_a (cfg_a),
        .reg_b (cfg_b),
        .reg_c (cfg_c)
    );

    ccp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .adc_req  (sample_evt),
        .adc_word (adc_word),
        .fwd_req  (fwd_req),
        .fwd_word (fwd_word),
        .bit_out  (bit_out),
        .frm_out  (frm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_word  <= '0;
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= dac_ld;
            if (dac_ld) dac_word <= rx_word;
        end
    end

    assert_dac_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        dac_valid |=> !dac_valid);
endmodule

// File: tb/chain_codec_port_tb.sv
module chain_codec_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_evt = 1'b0;
    logic [15:0] adc_word = '0;
    logic        frm_in = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_out, frm_out, dac_valid;
    logic [15:0] dac_word;
    logic [7:0]  cfg_a, cfg_b, cfg_c;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int t_send = 0;
    bit finished = 1'b0;

    // output capture
    int          cap_n = 0;
    int          cap_left = 0;
    int          fso_cyc = 0;
    logic [15:0] cap_sh = '0;
    logic [15:0] cap_w = '0;

    chain_codec_port u_dut (
        .clk(clk), .rst(rst), .sample_evt(sample_evt), .adc_word(adc_word),
        .frm_in(frm_in), .bit_in(bit_in), .bit_out(bit_out), .frm_out(frm_out),
        .dac_word(dac_word), .dac_valid(dac_valid),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cap_left > 0) begin
            cap_sh   = {cap_sh[14:0], bit_out};
            cap_left = cap_left - 1;
            if (cap_left == 0) begin
                cap_w = cap_sh;
                cap_n = cap_n + 1;
            end
        end else if (frm_out) begin
            cap_left = 16;
            fso_cyc  = cyc;
        end
    end

    // {input, forwarded, expected output, cfg_b after, cfg_c after}
    localparam logic [48:0] VEC [8] = '{
        {16'h1234, 1'b1, 16'h1234, 8'h00, 8'h00},  // R5
        {16'h0000, 1'b1, 16'h0000, 8'h00, 8'h00},  // R5
        {16'h9155, 1'b1, 16'h8155, 8'h00, 8'h00},  // R4
        {16'hF2AA, 1'b1, 16'hE2AA, 8'h00, 8'h00},  // R4
        {16'hA0FF, 1'b1, 16'h90FF, 8'h00, 8'h00},  // R4
        {16'h8133, 1'b0, 16'h0000, 8'h33, 8'h00},  // R3
        {16'h8244, 1'b0, 16'h0000, 8'h33, 8'h44},  // R3
        {16'h8377, 1'b0, 16'h0000, 8'h33, 8'h44}   // R3 reserved selector
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w, input bit mid_chk, input logic [7:0] mid_b);
        @(negedge clk);
        t_send = cyc;
        frm_in = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            frm_in = 1'b0;
            bit_in = w[i];
        end
        if (mid_chk) chk("R7 old value before last edge", {8'h00, cfg_b}, {8'h00, mid_b});
        @(negedge clk);
        bit_in = 1'b0;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    // send a data-mode word and check whether it is kept or passed on
    task automatic data_word(input logic [15:0] w, input bit keep, input string tag);
        int n0;
        n0 = cap_n;
        send_word(w, 1'b0, 8'h00);
        chk({tag, " dac_valid"}, {15'd0, dac_valid}, {15'd0, keep});
        if (keep) chk({tag, " dac_word"}, dac_word, w);
        settle();
        chk({tag, " forward count"}, 16'(cap_n - n0), keep ? 16'd0 : 16'd1);
        if (!keep) chk({tag, " forward word"}, cap_w, w);
    endtask

    task automatic sample(input logic [15:0] w);
        int n0, t0;
        n0 = cap_n;
        @(negedge clk);
        adc_word   = w;
        sample_evt = 1'b1;
        t0 = cyc;
        @(negedge clk);
        sample_evt = 1'b0;
        settle();
        chk("R6 adc word sent", cap_w, w);
        chk("R6 one frame", 16'(cap_n - n0), 16'd1);
        chk("R6 latency", 16'(fso_cyc - t0), 16'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 cfg_a in reset", {8'h00, cfg_a}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cfg_a", {8'h00, cfg_a}, 16'h0000);
        chk("R1 cfg_b", {8'h00, cfg_b}, 16'h0000);
        chk("R1 cfg_c", {8'h00, cfg_c}, 16'h0000);
        chk("R1 outputs quiet", {13'd0, frm_out, bit_out, dac_valid}, 16'h0000);

        // program-mode vector walk: R3 R4 R5
        foreach (VEC[k]) begin
            int n0;
            n0 = cap_n;
            send_word(VEC[k][48:33], 1'b0, 8'h00);
            settle();
            chk($sformatf("R3/R4/R5 vec%0d forward count", k), 16'(cap_n - n0), {15'd0, VEC[k][32]});
            if (VEC[k][32]) begin
                chk($sformatf("R4/R5 vec%0d word", k), cap_w, VEC[k][31:16]);
                chk($sformatf("R4/R5 vec%0d latency", k), 16'(fso_cyc - t_send), 16'd18);
            end
            chk($sformatf("R3 vec%0d cfg_b", k), {8'h00, cfg_b}, {8'h00, VEC[k][15:8]});
            chk($sformatf("R3 vec%0d cfg_c", k), {8'h00, cfg_c}, {8'h00, VEC[k][7:0]});
            chk($sformatf("R3 vec%0d cfg_a", k), {8'h00, cfg_a}, 16'h0000);
        end

        // R7: old value holds until the edge sampling bit 0
        send_word(16'h8166, 1'b1, 8'h33);
        chk("R7 new value at word end", {8'h00, cfg_b}, 16'h0066);
        settle();

        // R6: own sample transmission
        sample(16'hC3A5);
        sample(16'h0F1E);

        // R8/R9/R10 data mode with chain length 2
        send_word(16'h8082, 1'b0, 8'h00);
        chk("R10 mode readback", {8'h00, cfg_a}, 16'h0082);
        settle();
        data_word(16'hB123, 1'b0, "R8 control-like word passed");
        data_word(16'h4567, 1'b1, "R9 second word kept");
        data_word(16'h8001, 1'b0, "R9 count restarted");
        chk("R8 no register write in data mode", {8'h00, cfg_a}, 16'h0082);
        data_word(16'h2222, 1'b1, "R9 group two kept");
        chk("R10 still data mode", {8'h00, cfg_a}, 16'h0082);

        // R8: length field 0 means 8
        do_reset();
        send_word(16'h8080, 1'b0, 8'h00);
        settle();
        for (int i = 0; i < 7; i++) data_word(16'h1000 + 16'(i), 1'b0, "R8 length8 early");
        data_word(16'h5A5A, 1'b1, "R8 length8 eighth");

        // R9: length 1 keeps every word
        do_reset();
        send_word(16'h8081, 1'b0, 8'h00);
        settle();
        data_word(16'h0F0F, 1'b1, "R9 length1 first");
        data_word(16'h7777, 1'b1, "R9 length1 second");

        // R10: reset leaves data mode
        do_reset();
        @(negedge clk);
        chk("R10 reset to program mode", {8'h00, cfg_a}, 16'h0000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule